// File: doc/BRIEF.md
# Dual-Unit Register Transfer Datapath

This block holds four 8-bit registers and feeds an adder and a subtractor from them every cycle. Each unit has its own pair of 2-bit operand selects and its own 2-bit destination select. Any register may be picked as the first operand, the second operand and the destination at the same time, and the same register may fill all three roles. Both results are formed in every cycle. The control inputs then decide which results go back into the register file at the clock edge.

There are two commit modes. In single-write mode one result is stored, and a pick input names which one. In dual-write mode the sum and the difference are stored in the same edge, to two different registers. A dual-write request whose two destinations are equal is illegal. In that case the block raises a flag and stores only the sum. A load port presets any register from outside, and a synchronous reset clears the whole file.

The write decision is made by a small decoder with enumerated write plans, listed here with the condition that selects each one:
- PLAN_IDLE: no commit is requested, or a load is in progress.
- PLAN_SUM: single-write mode with the sum picked.
- PLAN_DIFF: single-write mode with the difference picked.
- PLAN_BOTH: dual-write mode with distinct destinations.
- PLAN_CLASH: dual-write mode with equal destinations.

The plan is re-evaluated every cycle from the inputs. There are no transitions between plans.

Top module: `rtd_datapath`

## Requirements
- R1: When `rst` is high at a clock edge, all four registers read 0 after that edge.
- R2: When `load_en` is high, register `load_sel` takes `load_data` at the edge. No arithmetic result is written in that cycle.
- R3: The sum is reg[`add_src_a`] + reg[`add_src_b`] modulo 256. Both selects may name the same register.
- R4: The difference is reg[`sub_src_a`] − reg[`sub_src_b`] modulo 256. Both selects may name the same register.
- R5: With `commit_en`=1, `dual_mode`=0 and `pick_diff`=0, only register `add_dst` changes, and it takes the sum.
- R6: With `commit_en`=1, `dual_mode`=0 and `pick_diff`=1, only register `sub_dst` changes, and it takes the difference.
- R7: With `commit_en`=1, `dual_mode`=1 and `add_dst`≠`sub_dst`, both results are written at the same edge: the sum to `add_dst` and the difference to `sub_dst`.
- R8: With `commit_en`=1, `dual_mode`=1 and `add_dst`=`sub_dst` (and `load_en`=0), `dual_clash` is 1 and only the sum is stored. In every other case `dual_clash` is 0.
- R9: Operands are the register values from before the edge, so a register that is both source and destination is computed from its old value.
- R10: With `commit_en`=0 and `load_en`=0, all registers keep their values.

Register i occupies bits `reg_q[8*i+7 : 8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Preset one register from `load_data` |
| load_sel | input | 2 | Register index for the load |
| load_data | input | 8 | Value to load |
| commit_en | input | 1 | Store arithmetic results this cycle |
| dual_mode | input | 1 | 1 = dual-write, 0 = single-write |
| pick_diff | input | 1 | Single-write: 1 stores the difference, 0 stores the sum |
| add_src_a | input | 2 | Adder first operand select |
| add_src_b | input | 2 | Adder second operand select |
| add_dst | input | 2 | Adder destination |
| sub_src_a | input | 2 | Subtractor minuend select |
| sub_src_b | input | 2 | Subtractor subtrahend select |
| sub_dst | input | 2 | Subtractor destination |
| reg_q | output | 32 | Contents of all four registers |
| dual_clash | output | 1 | Illegal dual-write request (equal destinations) |

## Verification
Sums and differences are tried with distinct operands, with the same register as both operands, and with all three roles on one register. This separates a read of the old value from a read of the new one, and shows a swapped or duplicated mux select. Wrap-around cases (a sum past 255, a difference below 0) show whether the result is cut to 8 bits. Single-write with each pick, dual-write to distinct registers and dual-write to equal registers are each compared against the registers that must not change. This exposes stray enables and a wrong priority on a clash. Loads made together with a commit request confirm that the commit is suppressed.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
    localparam int DATA_W = 8;
    localparam int NREGS  = 4;
    localparam int IDX_W  = $clog2(NREGS);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [2:0] {
        PLAN_IDLE  = 3'd0,
        PLAN_SUM   = 3'd1,
        PLAN_DIFF  = 3'd2,
        PLAN_BOTH  = 3'd3,
        PLAN_CLASH = 3'd4
    } plan_e;
endpackage

// File: rtl/rtd_operand_unit.sv
module rtd_operand_unit
    import rtd_pkg::*;
#(
    parameter bit DO_SUB = 1'b0
) (
    input  logic [DATA_W*NREGS-1:0] regs,
    input  idx_t                    sel_a,
    input  idx_t                    sel_b,
    output word_t                   result
);
    word_t opa;
    word_t opb;

    always_comb begin
        opa = regs[sel_a*DATA_W +: DATA_W];
        opb = regs[sel_b*DATA_W +: DATA_W];
    end

    generate
        if (DO_SUB) begin : g_sub
            assign result = opa - opb;
        end else begin : g_add
            assign result = opa + opb;
        end
    endgenerate
endmodule

// File: rtl/rtd_write_ctrl.sv
module rtd_write_ctrl
    import rtd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_en,
    input  logic commit_en,
    input  logic dual_mode,
    input  logic pick_diff,
    input  idx_t add_dst,
    input  idx_t sub_dst,
    output logic add_we,
    output logic sub_we,
    output logic clash
);
    plan_e plan;

    always_comb begin
        if (!commit_en || load_en)  plan = PLAN_IDLE;
        else if (!dual_mode)        plan = pick_diff ? PLAN_DIFF : PLAN_SUM;
        else if (add_dst == sub_dst) plan = PLAN_CLASH;
        else                        plan = PLAN_BOTH;
    end

    always_comb begin
        add_we = 1'b0;
        sub_we = 1'b0;
        clash  = 1'b0;
        unique case (plan)
            PLAN_IDLE:  ;
            PLAN_SUM:   add_we = 1'b1;
            PLAN_DIFF:  sub_we = 1'b1;
            PLAN_BOTH:  begin add_we = 1'b1; sub_we = 1'b1; end
            PLAN_CLASH: begin add_we = 1'b1; clash = 1'b1; end
            default:    ;
        endcase
    end

    // R7: two enables together never hit the same register
    p_distinct_dst_r7: assert property (@(posedge clk) disable iff (rst)
        (add_we && sub_we) |-> (add_dst != sub_dst));
    // R8: a clash keeps the subtractor from writing
    p_clash_sum_only_r8: assert property (@(posedge clk) disable iff (rst)
        clash |-> (add_we && !sub_we));
    // R2: a load blocks all arithmetic writes
    p_load_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        load_en |-> (!add_we && !sub_we && !clash));
endmodule

// File: rtl/rtd_regfile.sv
module rtd_regfile
    import rtd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_en,
    input  idx_t                    load_sel,
    input  word_t                   load_data,
    input  logic                    we0,
    input  idx_t                    dst0,
    input  word_t                   d0,
    input  logic                    we1,
    input  idx_t                    dst1,
    input  word_t                   d1,
    output logic [DATA_W*NREGS-1:0] q
);
    generate
        for (genvar i = 0; i < NREGS; i++) begin : g_reg
            word_t r;
            always_ff @(posedge clk) begin
                if (rst)                                r <= '0;
                else if (load_en && load_sel == idx_t'(i)) r <= load_data;
                else if (!load_en && we0 && dst0 == idx_t'(i)) r <= d0;
                else if (!load_en && we1 && dst1 == idx_t'(i)) r <= d1;
            end
            assign q[i*DATA_W +: DATA_W] = r;
        end
    endgenerate

    // R10: no write request leaves the file unchanged
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !we0 && !we1) |=> $stable(q));
    // R2: loaded register holds the load value
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (q[$past(load_sel)*DATA_W +: DATA_W] == $past(load_data)));
    // R1: reset clears everything
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q == '0));
endmodule

// File: rtl/rtd_datapath.sv
module rtd_datapath
    import rtd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_en,
    input  logic [1:0]  load_sel,
    input  logic [7:0]  load_data,
    input  logic        commit_en,
    input  logic        dual_mode,
    input  logic        pick_diff,
    input  logic [1:0]  add_src_a,
    input  logic [1:0]  add_src_b,
    input  logic [1:0]  add_dst,
    input  logic [1:0]  sub_src_a,
    input  logic [1:0]  sub_src_b,
    input  logic [1:0]  sub_dst,
    output logic [31:0] reg_q,
    output logic        dual_clash
);
    word_t sum_w;
    word_t diff_w;
    logic  add_we;
    logic  sub_we;

    rtd_operand_unit #(.DO_SUB(1'b0)) u_add (
        .regs(reg_q), .sel_a(add_src_a), .sel_b(add_src_b), .result(sum_w));

    rtd_operand_unit #(.DO_SUB(1'b1)) u_sub (
        .regs(reg_q), .sel_a(sub_src_a), .sel_b(sub_src_b), .result(diff_w));

    rtd_write_ctrl u_ctrl (
        .clk(clk), .rst(rst), .load_en(load_en), .commit_en(commit_en),
        .dual_mode(dual_mode), .pick_diff(pick_diff),
        .add_dst(add_dst), .sub_dst(sub_dst),
        .add_we(add_we), .sub_we(sub_we), .clash(dual_clash));

    rtd_regfile u_rf (
        .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel),
        .load_data(load_data),
        .we0(add_we), .dst0(add_dst), .d0(sum_w),
        .we1(sub_we), .dst1(sub_dst), .d1(diff_w),
        .q(reg_q));

    // R5/R9: a committed sum lands in its destination from pre-edge operands
    p_sum_lands_r5: assert property (@(posedge clk) disable iff (rst)
        add_we |=> (reg_q[$past(add_dst)*8 +: 8] == $past(sum_w)));
    // R6: a committed difference lands in its destination
    p_diff_lands_r6: assert property (@(posedge clk) disable iff (rst)
        sub_we |=> (reg_q[$past(sub_dst)*8 +: 8] == $past(diff_w)));
endmodule

// File: tb/rtd_datapath_tb.sv
module rtd_datapath_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        load_en, commit_en, dual_mode, pick_diff;
    logic [1:0]  load_sel, add_src_a, add_src_b, add_dst, sub_src_a, sub_src_b, sub_dst;
    logic [7:0]  load_data;
    logic [31:0] reg_q;
    logic        dual_clash;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [4];

    always #4 clk = ~clk;

    rtd_datapath u_dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel),
        .load_data(load_data), .commit_en(commit_en), .dual_mode(dual_mode),
        .pick_diff(pick_diff), .add_src_a(add_src_a), .add_src_b(add_src_b),
        .add_dst(add_dst), .sub_src_a(sub_src_a), .sub_src_b(sub_src_b),
        .sub_dst(sub_dst), .reg_q(reg_q), .dual_clash(dual_clash));

    task automatic check_regs(input string req);
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (reg_q[i*8 +: 8] !== model[i]) begin
                fails++;
                $display("FAIL %s reg%0d actual=%0d expected=%0d", req, i, reg_q[i*8 +: 8], model[i]);
            end
        end
    endtask

    task automatic check_clash(input string req, input logic exp);
        checks++;
        if (dual_clash !== exp) begin
            fails++;
            $display("FAIL %s dual_clash actual=%b expected=%b", req, dual_clash, exp);
        end
    endtask

    task automatic idle_inputs;
        load_en = 0; commit_en = 0; dual_mode = 0; pick_diff = 0;
        load_sel = 0; load_data = 0;
        add_src_a = 0; add_src_b = 0; add_dst = 0;
        sub_src_a = 0; sub_src_b = 0; sub_dst = 0;
    endtask

    task automatic load_reg(input logic [1:0] idx, input logic [7:0] val);
        @(negedge clk);
        idle_inputs();
        load_en = 1; load_sel = idx; load_data = val;
        @(posedge clk); @(negedge clk);
        model[idx] = val;
        load_en = 0;
        check_regs("R2");
    endtask

    // one arithmetic cycle; expected values come from the model before the edge
    task automatic do_op(input string req, input logic dual, input logic pick,
                         input logic [1:0] aa, input logic [1:0] ab, input logic [1:0] ad,
                         input logic [1:0] sa, input logic [1:0] sb, input logic [1:0] sd);
        logic [7:0] s, d;
        logic clash;
        @(negedge clk);
        idle_inputs();
        commit_en = 1; dual_mode = dual; pick_diff = pick;
        add_src_a = aa; add_src_b = ab; add_dst = ad;
        sub_src_a = sa; sub_src_b = sb; sub_dst = sd;
        s = model[aa] + model[ab];
        d = model[sa] - model[sb];
        clash = dual && (ad == sd);
        #1 check_clash(req, clash);
        @(posedge clk); @(negedge clk);
        if (!dual) begin
            if (pick) model[sd] = d; else model[ad] = s;
        end else begin
            model[ad] = s;
            if (!clash) model[sd] = d;
        end
        idle_inputs();
        check_regs(req);
    endtask

    task automatic t_reset;
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(posedge clk); @(negedge clk);
        rst = 0;
        for (int i = 0; i < 4; i++) model[i] = 8'd0;
        check_regs("R1");
        check_clash("R8", 1'b0);
    endtask

    task automatic t_load;
        load_reg(0, 8'd10); load_reg(1, 8'd3); load_reg(2, 8'd200); load_reg(3, 8'd77);
    endtask

    task automatic t_hold;
        @(negedge clk);
        idle_inputs();
        add_src_a = 1; add_dst = 2; sub_dst = 3; dual_mode = 1;
        @(posedge clk); @(negedge clk);
        check_regs("R10");
    endtask

    task automatic t_single;
        do_op("R5 R3", 0, 0, 0, 1, 3, 2, 1, 0);   // r3 = 10+3, r0 untouched
        do_op("R6 R4", 0, 1, 0, 0, 1, 2, 0, 1);   // r1 = 200-10
        do_op("R3 wrap", 0, 0, 2, 2, 0, 0, 0, 0); // r0 = 200+200 mod 256
        do_op("R4 wrap", 0, 1, 0, 0, 0, 1, 2, 3); // r3 = r1 - r2 below zero
    endtask

    task automatic t_same_reg;
        do_op("R9 R3", 0, 0, 1, 1, 1, 0, 0, 0);   // r1 = r1 + r1
        do_op("R9 R4", 0, 1, 0, 0, 0, 2, 2, 2);   // r2 = r2 - r2 = 0
    endtask

    task automatic t_dual;
        load_reg(0, 8'd50); load_reg(1, 8'd20); load_reg(2, 8'd5); load_reg(3, 8'd9);
        do_op("R7", 1, 0, 0, 1, 2, 0, 1, 3);      // r2=70, r3=30
        do_op("R7 R9", 1, 0, 0, 0, 1, 1, 0, 0);   // r1=100, r0=20-50
    endtask

    task automatic t_clash;
        do_op("R8", 1, 0, 2, 3, 1, 3, 2, 1);      // only sum into r1
        do_op("R8 pick", 1, 1, 0, 1, 0, 1, 0, 0); // pick ignored in dual
    endtask

    task automatic t_load_priority;
        @(negedge clk);
        idle_inputs();
        load_en = 1; load_sel = 3; load_data = 8'd123;
        commit_en = 1; dual_mode = 1; add_src_a = 0; add_dst = 0; sub_dst = 0;
        #1 check_clash("R8 load", 1'b0);
        @(posedge clk); @(negedge clk);
        model[3] = 8'd123;
        idle_inputs();
        check_regs("R2 priority");
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (2) @(posedge clk);
        t_reset();
        t_load();
        t_hold();
        t_single();
        t_same_reg();
        t_dual();
        t_clash();
        t_load_priority();
        t_reset();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule